// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches 32 general-purpose input pins and turns their activity into interrupt status, under control of a small bank of 16-bit registers. Every register exists as a pair: the word at the even offset covers pins 0 to 15 and the word two bytes above covers pins 16 to 31. Each pin can be set for level sensing with a chosen active polarity, or for edge sensing on the rising edge, the falling edge or both. In edge mode a pin either keeps its event in a status latch until software clears it, or shows the event for a single cycle only.

Status bits that are also enabled are combined into one interrupt line. A priority encoder reports the lowest-numbered enabled pending pin, and it searches the low half before the high half. The same register bank also holds a direction mask and an output data word for the pads, and it returns the synchronised pin levels on reads.

Top module: `gpint_unit`

## Requirements
- R1: After reset every configuration register (direction, output data, enable, type, level, hold, falling, rising) reads 0, `irq` and `pend_valid` are 0, `pend_idx` is 0 and `pin_oe`/`pin_out` are 0.
- R2: Register byte offsets: direction 0x00/0x02, pin data 0x04/0x06, status 0x08/0x0A, enable 0x0C/0x0E, type 0x10/0x12, level 0x14/0x16, hold 0x18/0x1A, falling 0x20/0x22, rising 0x24/0x26. The first offset of each pair holds pins 0-15 in bits 0-15 and the second holds pins 16-31 in bits 0-15. Any other offset reads 0 and ignores writes.
- R3: Pin inputs pass through two flops. A read of the pin-data offsets returns the new level once two rising clock edges have passed since the change, and the old level after only one. Writes to the pin-data offsets set `pin_out`, and the direction register drives `pin_oe` bit for bit.
- R4: Type bit 0 selects level mode: the status bit reads 1 while the synchronised pin equals its level bit (1 = active high, 0 = active low). A write-1 to status has no effect while the level is active.
- R5: Type bit 1 selects edge mode. An edge is a difference between the synchronised level and its value one cycle earlier. A rising edge counts only if the rising bit is 1, and a falling edge counts only if the falling bit is 1.
- R6: In edge mode with hold bit 1, a counted edge sets the status bit and it stays 1 until a write with that bit at 1. Writing 0 to a status bit leaves it unchanged.
- R7: In edge mode with hold bit 0, the status bit is 1 for exactly the one cycle in which the counted edge is seen.
- R8: When a counted edge and a write-1 to the same held status bit fall in the same cycle, the bit stays 1.
- R9: `irq` is 1 exactly when some pin has both its status bit and its enable bit at 1. A pending pin whose enable is 0 does not raise `irq`.
- R10: `pend_valid` equals `irq`. `pend_idx` gives the lowest-numbered pin with status and enable both 1, and any such pin among 0-15 wins over pins 16-31. When nothing is pending, `pend_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register bank |
| reg_addr | input | 6 | Byte offset of the accessed 16-bit word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_oe | output | 32 | Output-enable mask from the direction register |
| pin_out | output | 32 | Output data register |
| irq | output | 1 | Combined interrupt |
| pend_valid | output | 1 | At least one enabled pin is pending |
| pend_idx | output | 5 | Lowest pending pin, low half first |

## Verification
Every cycle, the assertions check that the encoder agrees with the combined interrupt, that the reported pin is pending and no lower pin is, that a held status bit only rises when a counted edge was seen, and that a counted edge is never lost to a clear in the same cycle. The bench scenarios cover what depends on configuration and on sequences of pin activity: the offset map and half split, the two-flop read latency, the level polarities, the edge qualifiers, the one-cycle pass-through pulse and write-0 leaving status unchanged.

// File: rtl/gpint_pkg.sv
package gpint_pkg;

    localparam int ADDR_W = 6;

    // register selector, one entry per low/high register pair
    typedef enum logic [3:0] {
        SEL_DIR  = 4'd0,
        SEL_DATA = 4'd1,
        SEL_STAT = 4'd2,
        SEL_EN   = 4'd3,
        SEL_TYPE = 4'd4,
        SEL_LVL  = 4'd5,
        SEL_HOLD = 4'd6,
        SEL_FALL = 4'd7,
        SEL_RISE = 4'd8,
        SEL_NONE = 4'd9
    } reg_sel_e;

    localparam int NUM_SEL = 9;

    typedef struct packed {
        reg_sel_e sel;
        logic     hi;
    } reg_dec_t;

    // byte offset -> register pair and half; bit 0 of the offset is ignored
    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.hi = a[1];
        unique case (a[ADDR_W-1:2])
            4'h0:    d.sel = SEL_DIR;
            4'h1:    d.sel = SEL_DATA;
            4'h2:    d.sel = SEL_STAT;
            4'h3:    d.sel = SEL_EN;
            4'h4:    d.sel = SEL_TYPE;
            4'h5:    d.sel = SEL_LVL;
            4'h6:    d.sel = SEL_HOLD;
            4'h8:    d.sel = SEL_FALL;
            4'h9:    d.sel = SEL_RISE;
            default: d.sel = SEL_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpint_sync.sv
module gpint_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;

endmodule

// File: rtl/gpint_detect.sv
module gpint_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] edge_mode,
    input  logic [W-1:0] lvl_high,
    input  logic [W-1:0] fall_ok,
    input  logic [W-1:0] rise_ok,
    input  logic [W-1:0] hold,
    output logic [W-1:0] live_evt,
    output logic [W-1:0] latch_set,
    output logic [W-1:0] use_latch
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rose;
        logic fell;
        logic edge_hit;
        logic lvl_hit;

        always_comb begin
            rose      = cur[i] & ~prev[i];
            fell      = ~cur[i] & prev[i];
            edge_hit  = (rose & rise_ok[i]) | (fell & fall_ok[i]);
            lvl_hit   = (cur[i] == lvl_high[i]);
            live_evt[i]  = edge_mode[i] ? edge_hit : lvl_hit;
            use_latch[i] = edge_mode[i] & hold[i];
            latch_set[i] = edge_mode[i] & hold[i] & edge_hit;
        end
    end

endmodule

// File: rtl/gpint_regs.sv
module gpint_regs
    import gpint_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int PIN_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    input  logic [PIN_W-1:0]  pin_sync,
    input  logic [PIN_W-1:0]  live_evt,
    input  logic [PIN_W-1:0]  latch_set,
    input  logic [PIN_W-1:0]  use_latch,
    output logic [PIN_W-1:0]  cfg_dir,
    output logic [PIN_W-1:0]  cfg_out,
    output logic [PIN_W-1:0]  cfg_en,
    output logic [PIN_W-1:0]  cfg_type,
    output logic [PIN_W-1:0]  cfg_lvl,
    output logic [PIN_W-1:0]  cfg_hold,
    output logic [PIN_W-1:0]  cfg_fall,
    output logic [PIN_W-1:0]  cfg_rise,
    output logic [PIN_W-1:0]  status,
    output logic [PIN_W-1:0]  latch_vec
);

    reg_dec_t          dec;
    logic [PIN_W-1:0]  cfg_q [NUM_SEL];
    logic [PIN_W-1:0]  latch_q;
    logic [PIN_W-1:0]  clr_mask;
    logic              cfg_wr;

    assign dec    = decode_addr(reg_addr);
    assign cfg_wr = reg_wr && (dec.sel != SEL_STAT) && (dec.sel != SEL_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SEL; k++) begin
                cfg_q[k] <= '0;
            end
        end else if (cfg_wr) begin
            if (dec.hi) begin
                cfg_q[dec.sel][PIN_W-1:HALF_W] <= reg_wdata;
            end else begin
                cfg_q[dec.sel][HALF_W-1:0] <= reg_wdata;
            end
        end
    end

    always_comb begin
        clr_mask = '0;
        if (reg_wr && dec.sel == SEL_STAT) begin
            if (dec.hi) begin
                clr_mask[PIN_W-1:HALF_W] = reg_wdata;
            end else begin
                clr_mask[HALF_W-1:0] = reg_wdata;
            end
        end
    end

    // set has priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= use_latch & ((latch_q & ~clr_mask) | latch_set);
        end
    end

    assign status    = (use_latch & latch_q) | (~use_latch & live_evt);
    assign latch_vec = latch_q;

    assign cfg_dir  = cfg_q[SEL_DIR];
    assign cfg_out  = cfg_q[SEL_DATA];
    assign cfg_en   = cfg_q[SEL_EN];
    assign cfg_type = cfg_q[SEL_TYPE];
    assign cfg_lvl  = cfg_q[SEL_LVL];
    assign cfg_hold = cfg_q[SEL_HOLD];
    assign cfg_fall = cfg_q[SEL_FALL];
    assign cfg_rise = cfg_q[SEL_RISE];

    logic [PIN_W-1:0] rd_vec;

    always_comb begin
        unique case (dec.sel)
            SEL_DATA: rd_vec = pin_sync;
            SEL_STAT: rd_vec = status;
            SEL_NONE: rd_vec = '0;
            default:  rd_vec = cfg_q[dec.sel];
        endcase
        reg_rdata = dec.hi ? rd_vec[PIN_W-1:HALF_W] : rd_vec[HALF_W-1:0];
    end

endmodule

// File: rtl/gpint_prio.sv
module gpint_prio #(
    parameter int HALF_W = 16,
    localparam int PIN_W  = 2 * HALF_W,
    localparam int HIDX_W = $clog2(HALF_W),
    localparam int IDX_W  = $clog2(PIN_W)
) (
    input  logic [PIN_W-1:0] pend,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);

    logic [1:0]        half_any;
    logic [HIDX_W-1:0] half_idx [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] slice;
        assign slice       = pend[h*HALF_W +: HALF_W];
        assign half_any[h] = |slice;

        always_comb begin
            half_idx[h] = '0;
            for (int b = HALF_W - 1; b >= 0; b--) begin
                if (slice[b]) begin
                    half_idx[h] = HIDX_W'(b);
                end
            end
        end
    end

    // low half first; high half only when the low half is idle
    always_comb begin
        valid = |half_any;
        if (half_any[0]) begin
            idx = {1'b0, half_idx[0]};
        end else if (half_any[1]) begin
            idx = {1'b1, half_idx[1]};
        end else begin
            idx = '0;
        end
    end

endmodule

// File: rtl/gpint_unit.sv
module gpint_unit
    import gpint_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int PIN_W = 2 * HALF_W,
    localparam int IDX_W = $clog2(PIN_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pin_out,
    output logic              irq,
    output logic              pend_valid,
    output logic [IDX_W-1:0]  pend_idx
);

    logic [PIN_W-1:0] pin_cur;
    logic [PIN_W-1:0] pin_prev;
    logic [PIN_W-1:0] live_evt;
    logic [PIN_W-1:0] set_vec;
    logic [PIN_W-1:0] use_latch;
    logic [PIN_W-1:0] cfg_en;
    logic [PIN_W-1:0] cfg_type;
    logic [PIN_W-1:0] cfg_lvl;
    logic [PIN_W-1:0] cfg_hold;
    logic [PIN_W-1:0] cfg_fall;
    logic [PIN_W-1:0] cfg_rise;
    logic [PIN_W-1:0] stat_vec;
    logic [PIN_W-1:0] latch_vec;
    logic [PIN_W-1:0] pend_vec;

    gpint_sync #(.W(PIN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_in),
        .cur   (pin_cur),
        .prev  (pin_prev)
    );

    gpint_detect #(.W(PIN_W)) u_detect (
        .cur       (pin_cur),
        .prev      (pin_prev),
        .edge_mode (cfg_type),
        .lvl_high  (cfg_lvl),
        .fall_ok   (cfg_fall),
        .rise_ok   (cfg_rise),
        .hold      (cfg_hold),
        .live_evt  (live_evt),
        .latch_set (set_vec),
        .use_latch (use_latch)
    );

    gpint_regs #(.HALF_W(HALF_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_sync  (pin_cur),
        .live_evt  (live_evt),
        .latch_set (set_vec),
        .use_latch (use_latch),
        .cfg_dir   (pin_oe),
        .cfg_out   (pin_out),
        .cfg_en    (cfg_en),
        .cfg_type  (cfg_type),
        .cfg_lvl   (cfg_lvl),
        .cfg_hold  (cfg_hold),
        .cfg_fall  (cfg_fall),
        .cfg_rise  (cfg_rise),
        .status    (stat_vec),
        .latch_vec (latch_vec)
    );

    assign pend_vec = stat_vec & cfg_en;
    assign irq      = |pend_vec;

    gpint_prio #(.HALF_W(HALF_W)) u_prio (
        .pend  (pend_vec),
        .valid (pend_valid),
        .idx   (pend_idx)
    );

endmodule

// File: rtl/gpint_chk.sv
module gpint_chk #(
    parameter int HALF_W = 16,
    localparam int PIN_W = 2 * HALF_W,
    localparam int IDX_W = $clog2(PIN_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             pend_valid,
    input logic [IDX_W-1:0] pend_idx,
    input logic [PIN_W-1:0] pend_vec,
    input logic [PIN_W-1:0] latch_vec,
    input logic [PIN_W-1:0] set_vec
);

    // R10
    valid_matches_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid == irq);

    // R10
    idx_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> pend_vec[pend_idx]);

    // R10
    idx_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> ((pend_vec & ((PIN_W'(1) << pend_idx) - PIN_W'(1))) == '0));

    // R10
    idle_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> (pend_idx == '0));

    // R6
    latch_rises_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0) |=> ((latch_vec & ~$past(latch_vec)) == '0));

    // R8
    set_never_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((latch_vec & $past(set_vec)) == $past(set_vec)));

endmodule

bind gpint_unit gpint_chk #(.HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .pend_valid (pend_valid),
    .pend_idx   (pend_idx),
    .pend_vec   (pend_vec),
    .latch_vec  (latch_vec),
    .set_vec    (set_vec)
);

// File: tb/gpint_unit_tb.sv
`timescale 1ns/1ps
module gpint_unit_tb;

    localparam logic [5:0] A_DIR  = 6'h00;
    localparam logic [5:0] A_DATA = 6'h04;
    localparam logic [5:0] A_STAT = 6'h08;
    localparam logic [5:0] A_EN   = 6'h0C;
    localparam logic [5:0] A_TYPE = 6'h10;
    localparam logic [5:0] A_LVL  = 6'h14;
    localparam logic [5:0] A_HOLD = 6'h18;
    localparam logic [5:0] A_FALL = 6'h20;
    localparam logic [5:0] A_RISE = 6'h24;
    localparam logic [5:0] HI     = 6'h02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] pins = 32'hFFFF_FFFF;
    logic [31:0] pin_oe;
    logic [31:0] pin_out;
    logic        irq;
    logic        pend_valid;
    logic [4:0]  pend_idx;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpint_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pin_in     (pins),
        .pin_oe     (pin_oe),
        .pin_out    (pin_out),
        .irq        (irq),
        .pend_valid (pend_valid),
        .pend_idx   (pend_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // combinational read without waiting for an edge
    task automatic peek(input logic [5:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [15:0] exp);
        logic [15:0] d;
        peek(a, d);
        chk(req, {16'h0, d}, {16'h0, exp});
    endtask

    task automatic t_reset();
        rd_chk("R1 dir lo", A_DIR, 16'h0);      rd_chk("R1 dir hi", A_DIR | HI, 16'h0);
        rd_chk("R1 en lo", A_EN, 16'h0);        rd_chk("R1 en hi", A_EN | HI, 16'h0);
        rd_chk("R1 type", A_TYPE, 16'h0);       rd_chk("R1 lvl", A_LVL | HI, 16'h0);
        rd_chk("R1 hold", A_HOLD, 16'h0);       rd_chk("R1 fall", A_FALL, 16'h0);
        rd_chk("R1 rise", A_RISE | HI, 16'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 pend_valid", {31'h0, pend_valid}, 32'h0);
        chk("R1 pend_idx", {27'h0, pend_idx}, 32'h0);
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
    endtask

    task automatic t_regmap();
        wr(A_TYPE | HI, 16'h1357); wr(A_HOLD, 16'h2468);
        wr(A_FALL | HI, 16'hC3C3); wr(A_RISE, 16'h0F0F);
        wr(6'h1C, 16'hFFFF);       wr(6'h28, 16'hFFFF);
        @(negedge clk);
        rd_chk("R2 type hi", A_TYPE | HI, 16'h1357);
        rd_chk("R2 type lo untouched", A_TYPE, 16'h0);
        rd_chk("R2 hold lo", A_HOLD, 16'h2468);
        rd_chk("R2 fall hi", A_FALL | HI, 16'hC3C3);
        rd_chk("R2 rise lo", A_RISE, 16'h0F0F);
        rd_chk("R2 unmapped 0x1C", 6'h1C, 16'h0);
        rd_chk("R2 unmapped 0x28", 6'h28, 16'h0);
        wr(A_TYPE | HI, 16'h0); wr(A_HOLD, 16'h0);
        wr(A_FALL | HI, 16'h0); wr(A_RISE, 16'h0);
        @(negedge clk);
        rd_chk("R2 type hi cleared", A_TYPE | HI, 16'h0);
    endtask

    task automatic t_pindata();
        logic [15:0] d;
        wr(A_DIR, 16'h00F0); wr(A_DIR | HI, 16'hA000);
        wr(A_DATA, 16'h5A5A); wr(A_DATA | HI, 16'h0081);
        @(negedge clk);
        chk("R3 pin_oe", pin_oe, 32'hA000_00F0);
        chk("R3 pin_out", pin_out, 32'h0081_5A5A);
        pins = 32'h1234_ABCD;
        @(negedge clk);
        peek(A_DATA, d);
        chk("R3 old level after one edge", {16'h0, d}, 32'h0000_FFFF);
        @(negedge clk);
        rd_chk("R3 data lo after two edges", A_DATA, 16'hABCD);
        rd_chk("R3 data hi after two edges", A_DATA | HI, 16'h1234);
        pins = 32'hFFFF_FFFF;
        cyc(4);
    endtask

    task automatic t_level();
        wr(A_LVL, 16'h0008); wr(A_EN, 16'h0008);
        @(negedge clk);
        rd_chk("R4 active-high pin 3", A_STAT, 16'h0008);
        chk("R9 irq from pin 3", {31'h0, irq}, 32'h1);
        chk("R10 idx pin 3", {27'h0, pend_idx}, 32'd3);
        wr(A_STAT, 16'h0008);
        rd_chk("R4 clear ignored while active", A_STAT, 16'h0008);
        pins[3] = 1'b0;
        cyc(3);
        rd_chk("R4 inactive when low", A_STAT, 16'h0000);
        chk("R9 irq drops", {31'h0, irq}, 32'h0);
        wr(A_LVL, 16'h0000);
        rd_chk("R4 active-low pin 3", A_STAT, 16'h0008);
        pins[3] = 1'b1;
        wr(A_EN, 16'h0000);
        cyc(3);
        rd_chk("R4 active-low released", A_STAT, 16'h0000);
    endtask

    task automatic t_edge_hold();
        wr(A_TYPE | HI, 16'h0010); wr(A_HOLD | HI, 16'h0010);
        wr(A_RISE | HI, 16'h0010); wr(A_EN | HI, 16'h0010);
        @(negedge clk); pins[20] = 1'b0;
        cyc(4);
        rd_chk("R5 fall ignored in rise-only", A_STAT | HI, 16'h0000);
        pins[20] = 1'b1;
        cyc(4);
        rd_chk("R6 rise latched", A_STAT | HI, 16'h0010);
        chk("R10 idx pin 20", {27'h0, pend_idx}, 32'd20);
        cyc(3);
        rd_chk("R6 still held", A_STAT | HI, 16'h0010);
        wr(A_STAT | HI, 16'h0000);
        rd_chk("R6 write 0 keeps bit", A_STAT | HI, 16'h0010);
        wr(A_STAT | HI, 16'h0010);
        rd_chk("R6 write 1 clears", A_STAT | HI, 16'h0000);
        wr(A_RISE | HI, 16'h0000); wr(A_FALL | HI, 16'h0010);
        @(negedge clk); pins[20] = 1'b0;
        cyc(4);
        rd_chk("R5 fall-only latches fall", A_STAT | HI, 16'h0010);
        wr(A_STAT | HI, 16'h0010);
        pins[20] = 1'b1;
        cyc(4);
        rd_chk("R5 rise ignored in fall-only", A_STAT | HI, 16'h0000);
        wr(A_RISE | HI, 16'h0010);
        @(negedge clk); pins[20] = 1'b0;
        cyc(4);
        rd_chk("R5 both-edge fall", A_STAT | HI, 16'h0010);
        // R8: clear write lands on the edge that sets the bit again
        pins[20] = 1'b1;           // N0
        cyc(2);                    // N2
        reg_wr = 1'b1; reg_addr = A_STAT | HI; reg_wdata = 16'h0010;
        @(negedge clk);            // N3
        reg_wr = 1'b0;
        rd_chk("R8 set wins over clear", A_STAT | HI, 16'h0010);
        wr(A_STAT | HI, 16'h0010);
        rd_chk("R6 cleared afterwards", A_STAT | HI, 16'h0000);
        wr(A_EN | HI, 16'h0000);
    endtask

    task automatic t_thru();
        logic [15:0] d;
        wr(A_TYPE, 16'h0020); wr(A_RISE, 16'h0020); wr(A_EN, 16'h0020);
        @(negedge clk); pins[5] = 1'b0;
        cyc(4);
        rd_chk("R7 fall not counted", A_STAT, 16'h0000);
        pins[5] = 1'b1;            // N0
        @(negedge clk);            // N1
        peek(A_STAT, d);
        chk("R7 no pulse yet", {16'h0, d}, 32'h0);
        @(negedge clk);            // N2
        peek(A_STAT, d);
        chk("R7 pulse present", {16'h0, d}, 32'h0000_0020);
        chk("R9 irq on pulse", {31'h0, irq}, 32'h1);
        @(negedge clk);            // N3
        peek(A_STAT, d);
        chk("R7 pulse gone", {16'h0, d}, 32'h0);
        chk("R9 irq after pulse", {31'h0, irq}, 32'h0);
        wr(A_EN, 16'h0000);
    endtask

    task automatic t_prio();
        wr(A_LVL, 16'h0104); wr(A_LVL | HI, 16'h0041);
        wr(A_EN, 16'h0100);  wr(A_EN | HI, 16'h0041);
        @(negedge clk);
        chk("R10 low half wins", {27'h0, pend_idx}, 32'd8);
        chk("R10 valid", {31'h0, pend_valid}, 32'h1);
        wr(A_EN, 16'h0000);
        rd_chk("R9 pin 2 pending but masked", A_STAT, 16'h0104);
        chk("R10 high half lowest", {27'h0, pend_idx}, 32'd16);
        wr(A_EN | HI, 16'h0040);
        chk("R10 pin 22", {27'h0, pend_idx}, 32'd22);
        wr(A_EN | HI, 16'h0000);
        chk("R9 irq with nothing enabled", {31'h0, irq}, 32'h0);
        chk("R10 valid low", {31'h0, pend_valid}, 32'h0);
        chk("R10 idle idx", {27'h0, pend_idx}, 32'h0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(5);
        t_reset();
        t_regmap();
        t_pindata();
        t_level();
        t_edge_hold();
        t_thru();
        t_prio();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule